// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches three external interrupt pins and turns each one into a clean, active-high request for a parent interrupt controller. Each pin is brought into the clock domain through a synchroniser. It is then sampled only on cycles where one of two sample-enable strobes is high: a slow default strobe or a fast one, chosen per line. The block detects a high level, a low level, a rising edge or a falling edge, as configured for that line, and holds the result in a pending flag. The line's request output is the pending flag gated by the line's enable bit.

Software sees one 8-bit control byte per line, holding trigger type, enable, strobe select and the pending flag. A build parameter picks the register layout. In the first layout each line's byte sits in the low byte of its own word address. In the second, all three bytes are packed into one 32-bit word. Lines configured for low level or falling edge are inverted inside the block, so the parent only ever sees a high level or a rising edge.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every control byte reads 0 (high-level type, disabled, slow strobe, nothing pending) and every `irq_out` bit is 0.
- R2: In per-line layout (`SHARED=0`), line n's byte is at word address n, in bits 7:0. Within the byte, bit 0 is pending, bit 4 is strobe select, bit 5 is enable and bits 7:6 are trigger type (00 high, 01 low, 10 rise, 11 fall). Bits 3:1 and bits 31:8 read 0, and any other address reads 0. Read data is registered and appears one cycle after the address.
- R3: In shared layout (`SHARED=1`), all three bytes are in the single word at address 0, with line n in bits [(2-n)*8+7:(2-n)*8]. Line 0 is therefore in bits 23:16 and line 2 in bits 7:0. Other addresses read 0.
- R4: A pin passes through a two-flop synchroniser and is sampled only when the selected strobe is high: `slow_tick` when the select bit is 0, `fast_tick` when it is 1.
- R5: For level types the pending flag takes, at each sample, the result of matching the sampled level against the type (1 for high-level when the sample is 1, and for low-level when the sample is 0). Writing 1 to bit 0 has no effect on a level line.
- R6: For edge types the pending flag is set when two consecutive samples show the configured transition. It then stays set until software writes 1 to bit 0.
- R7: When a write-1 clear and a qualifying edge fall in the same sample cycle, the edge wins and the pending flag stays 1.
- R8: `irq_out[n]` is the line's enable AND its pending flag, registered one cycle. Clearing enable drives the output low but keeps a pending edge, and setting enable again raises the output.
- R9: Writing a different trigger type clears that line's pending flag and discards its stored sample, so the first sample after the change cannot produce an edge.
- R10: Low-level and falling-edge lines are presented to the parent as active-high requests: a low pin on a low-level line gives `irq_out` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | Slow sample-enable strobe |
| fast_tick | input | 1 | Fast sample-enable strobe |
| pin_in | input | 3 | Asynchronous external interrupt pins, one per line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| irq_out | output | 3 | Active-high request per line towards the parent |

## Verification
Two of the block's functions can hit the same cycle: a software write-1 clear of an edge line, and the sample strobe that detects a new edge on that line. The bench provokes the collision by making the fast strobe fire on every cycle. It raises the pin and counts the two synchroniser stages, then places the clearing write exactly on the edge where the detecting sample is taken. It judges the result by reading the pending bit back as 1 and seeing the request stay high. A behavioural model run every clock checks the same expectation, and the same clear issued with no edge present is checked to drop the flag.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  localparam int BYTE_W      = 8;
  localparam int POS_PEND    = 0;
  localparam int POS_SEL     = 4;
  localparam int POS_EN      = 5;
  localparam int POS_TRIG_LO = 6;

  function automatic logic [BYTE_W-1:0] pack_ctl(trig_e t, logic en, logic sel, logic pend);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[POS_TRIG_LO +: 2] = t;
    b[POS_EN]           = en;
    b[POS_SEL]          = sel;
    b[POS_PEND]         = pend;
    return b;
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0] chain [WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= '0;
      else     chain[i] <= {chain[i][STAGES-2:0], d[i]};
    end
    assign q[i] = chain[i][STAGES-1];
  end

endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
  import ext_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_sync,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic              cfg_wr,
  input  logic [BYTE_W-1:0] cfg_wbyte,
  output logic [BYTE_W-1:0] ctl_byte,
  output logic              irq,
  output logic              en_o,
  output logic              pend_o,
  output logic [1:0]        trig_o
);

  trig_e trig_q;
  logic  en_q, sel_q, pend_q, samp_q, samp_vld_q, irq_q;

  trig_e new_trig;
  logic  strobe, trig_chg, is_edge, rise, fall, hit, lvl_match, clr_req;

  always_comb begin
    new_trig  = trig_e'(cfg_wbyte[POS_TRIG_LO +: 2]);
    strobe    = sel_q ? fast_tick : slow_tick;
    trig_chg  = cfg_wr && (new_trig != trig_q);
    is_edge   = trig_q[1];
    rise      = samp_vld_q && !samp_q && pin_sync;
    fall      = samp_vld_q && samp_q && !pin_sync;
    hit       = (trig_q == TRIG_RISE) ? rise : fall;
    lvl_match = (trig_q == TRIG_HIGH) ? pin_sync : !pin_sync;
    clr_req   = cfg_wr && cfg_wbyte[POS_PEND];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q     <= TRIG_HIGH;
      en_q       <= 1'b0;
      sel_q      <= 1'b0;
      pend_q     <= 1'b0;
      samp_q     <= 1'b0;
      samp_vld_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (cfg_wr) begin
        trig_q <= new_trig;
        en_q   <= cfg_wbyte[POS_EN];
        sel_q  <= cfg_wbyte[POS_SEL];
      end
      if (trig_chg) begin
        pend_q     <= 1'b0;
        samp_vld_q <= 1'b0;
      end else begin
        if (strobe) begin
          samp_q     <= pin_sync;
          samp_vld_q <= 1'b1;
        end
        if (is_edge) begin
          if (strobe && hit) pend_q <= 1'b1;
          else if (clr_req)  pend_q <= 1'b0;
        end else if (strobe) begin
          pend_q <= lvl_match;
        end
      end
      irq_q <= en_q & pend_q;
    end
  end

  assign ctl_byte = pack_ctl(trig_q, en_q, sel_q, pend_q);
  assign irq      = irq_q;
  assign en_o     = en_q;
  assign pend_o   = pend_q;
  assign trig_o   = trig_q;

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int N_LINES = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter bit SHARED  = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  input  logic [N_LINES-1:0][BYTE_W-1:0] ctl_bytes,
  output logic [N_LINES-1:0]            line_wr,
  output logic [N_LINES-1:0][BYTE_W-1:0] line_wbyte,
  output logic [DATA_W-1:0]             reg_rdata
);

  localparam int PACK_W = N_LINES * BYTE_W;

  logic [DATA_W-1:0] rd_next;

  if (SHARED) begin : g_shared
    logic addr_hit;
    assign addr_hit = (reg_addr == '0);
    for (genvar n = 0; n < N_LINES; n++) begin : g_ln
      assign line_wr[n]    = reg_wr && addr_hit;
      assign line_wbyte[n] = reg_wdata[(N_LINES-1-n)*BYTE_W +: BYTE_W];
    end
    always_comb begin
      rd_next = '0;
      if (addr_hit) begin
        for (int n = 0; n < N_LINES; n++)
          rd_next[(N_LINES-1-n)*BYTE_W +: BYTE_W] = ctl_bytes[n];
      end
    end
  end else begin : g_per_line
    for (genvar n = 0; n < N_LINES; n++) begin : g_ln
      assign line_wr[n]    = reg_wr && (reg_addr == ADDR_W'(n));
      assign line_wbyte[n] = reg_wdata[BYTE_W-1:0];
    end
    always_comb begin
      rd_next = '0;
      for (int n = 0; n < N_LINES; n++)
        if (reg_addr == ADDR_W'(n)) rd_next[BYTE_W-1:0] = ctl_bytes[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  initial begin
    if (PACK_W > DATA_W) $error("control bytes do not fit in the data word");
  end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int N_LINES     = 3,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit SHARED      = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slow_tick,
  input  logic               fast_tick,
  input  logic [N_LINES-1:0] pin_in,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [N_LINES-1:0] irq_out
);

  logic [N_LINES-1:0]             pin_s;
  logic [N_LINES-1:0]             line_wr;
  logic [N_LINES-1:0][BYTE_W-1:0] line_wbyte;
  logic [N_LINES-1:0][BYTE_W-1:0] ctl_bytes;
  logic [N_LINES-1:0]             line_en;
  logic [N_LINES-1:0]             line_pend;
  logic [N_LINES-1:0][1:0]        line_trig;

  ext_irq_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  ext_irq_regs #(
    .N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHARED(SHARED)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ctl_bytes  (ctl_bytes),
    .line_wr    (line_wr),
    .line_wbyte (line_wbyte),
    .reg_rdata  (reg_rdata)
  );

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    ext_irq_line u_line (
      .clk       (clk),
      .rst       (rst),
      .pin_sync  (pin_s[n]),
      .slow_tick (slow_tick),
      .fast_tick (fast_tick),
      .cfg_wr    (line_wr[n]),
      .cfg_wbyte (line_wbyte[n]),
      .ctl_byte  (ctl_bytes[n]),
      .irq       (irq_out[n]),
      .en_o      (line_en[n]),
      .pend_o    (line_pend[n]),
      .trig_o    (line_trig[n])
    );
  end

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int N_LINES = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter bit SHARED  = 1'b0
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    slow_tick,
  input logic                    fast_tick,
  input logic                    reg_wr,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [DATA_W-1:0]       reg_wdata,
  input logic [N_LINES-1:0]      irq_out,
  input logic [N_LINES-1:0]      line_en,
  input logic [N_LINES-1:0]      line_pend,
  input logic [N_LINES-1:0][1:0] line_trig
);

  for (genvar n = 0; n < N_LINES; n++) begin : g_chk
    logic       wr_line;
    logic [7:0] wbyte;
    if (SHARED) begin : g_sh
      assign wr_line = reg_wr && (reg_addr == '0);
      assign wbyte   = reg_wdata[(N_LINES-1-n)*8 +: 8];
    end else begin : g_pl
      assign wr_line = reg_wr && (reg_addr == ADDR_W'(n));
      assign wbyte   = reg_wdata[7:0];
    end

    // R8: a disabled line drives no request on the next cycle
    a_r8_mask_forces_low: assert property (@(posedge clk) disable iff (rst)
      !line_en[n] |=> !irq_out[n]);

    // R8: a request is only raised from a pending flag
    a_r8_irq_from_pending: assert property (@(posedge clk) disable iff (rst)
      irq_out[n] |-> $past(line_pend[n]));

    // R4: pending can only be set on a cycle with a sample strobe
    a_r4_pend_on_strobe: assert property (@(posedge clk) disable iff (rst)
      $rose(line_pend[n]) |-> $past(slow_tick || fast_tick));

    // R6: an edge-type pending flag holds while software leaves the line alone
    a_r6_edge_pend_holds: assert property (@(posedge clk) disable iff (rst)
      (line_trig[n][1] && line_pend[n] && !wr_line) |=> line_pend[n]);

    // R9: writing a different trigger type leaves nothing pending
    a_r9_type_change_clears: assert property (@(posedge clk) disable iff (rst)
      (wr_line && (wbyte[7:6] != line_trig[n])) |=> !line_pend[n]);
  end

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(
  .N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHARED(SHARED)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .slow_tick (slow_tick),
  .fast_tick (fast_tick),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_out   (irq_out),
  .line_en   (line_en),
  .line_pend (line_pend),
  .line_trig (line_trig)
);

// File: tb/ext_irq_ctrl_test.sv
`timescale 1ns/1ps
module ext_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_tick = 1'b0, fast_tick = 1'b0;
  logic [2:0]  pin_in = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_out;

  logic        sh_wr = 1'b0;
  logic [3:0]  sh_addr = '0;
  logic [31:0] sh_wdata = '0;
  logic [31:0] sh_rdata;
  logic [2:0]  sh_irq;

  int checks = 0, errors = 0;
  int fast_period = 2, slow_period = 16;
  int fast_cnt = 0, slow_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl uut (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .pin_in(pin_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  ext_irq_ctrl #(.SHARED(1'b1)) uut_shared (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .pin_in(pin_in), .reg_wr(sh_wr), .reg_addr(sh_addr),
    .reg_wdata(sh_wdata), .reg_rdata(sh_rdata), .irq_out(sh_irq)
  );

  // strobe generator, driven away from the active edge
  always @(negedge clk) begin
    if (fast_period == 0) fast_tick = 1'b0;
    else begin
      fast_cnt = (fast_cnt + 1) % fast_period;
      fast_tick = (fast_cnt == 0);
    end
    if (slow_period == 0) slow_tick = 1'b0;
    else begin
      slow_cnt = (slow_cnt + 1) % slow_period;
      slow_tick = (slow_cnt == 0);
    end
  end

  // ---------------- behavioural reference for uut ----------------
  int m_s1[3], m_s2[3], m_samp[3], m_vld[3], m_pend[3], m_en[3], m_sel[3], m_trig[3];
  int m_irq[3];
  int m_rdata;

  function automatic int ctl_of(int n);
    return (m_trig[n] << 6) | (m_en[n] << 5) | (m_sel[n] << 4) | m_pend[n];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < 3; n++) begin
        m_s1[n] = 0; m_s2[n] = 0; m_samp[n] = 0; m_vld[n] = 0;
        m_pend[n] = 0; m_en[n] = 0; m_sel[n] = 0; m_trig[n] = 0; m_irq[n] = 0;
      end
      m_rdata = 0;
    end else begin
      m_rdata = (reg_addr < 3) ? ctl_of(int'(reg_addr)) : 0;
      for (int n = 0; n < 3; n++) begin
        int  cur, tick, wb, wr, edge_seen, want;
        cur  = m_s2[n];
        tick = m_sel[n] ? int'(fast_tick) : int'(slow_tick);
        wr   = reg_wr && (reg_addr == n);
        wb   = int'(reg_wdata[7:0]);
        m_irq[n] = m_en[n] & m_pend[n];
        if (wr && ((wb >> 6) != m_trig[n])) begin
          m_pend[n] = 0;
          m_vld[n]  = 0;
        end else begin
          if (m_trig[n] >= 2) begin
            edge_seen = m_vld[n] && tick &&
                        ((m_trig[n] == 2) ? (m_samp[n] == 0 && cur == 1)
                                          : (m_samp[n] == 1 && cur == 0));
            if (edge_seen) m_pend[n] = 1;
            else if (wr && (wb & 1)) m_pend[n] = 0;
          end else if (tick) begin
            want = (m_trig[n] == 0) ? cur : 1 - cur;
            m_pend[n] = want;
          end
          if (tick) begin m_samp[n] = cur; m_vld[n] = 1; end
        end
        if (wr) begin
          m_trig[n] = wb >> 6;
          m_en[n]   = (wb >> 5) & 1;
          m_sel[n]  = (wb >> 4) & 1;
        end
        m_s2[n] = m_s1[n];
        m_s1[n] = int'(pin_in[n]);
      end
    end
  end

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && !finished) begin
      for (int n = 0; n < 3; n++) begin
        checks++;
        if (int'(irq_out[n]) != m_irq[n]) begin
          errors++;
          $display("FAIL R8 model irq_out[%0d] actual=%0d expected=%0d t=%0t",
                   n, irq_out[n], m_irq[n], $time);
        end
      end
      checks++;
      if (int'(reg_rdata) != m_rdata) begin
        errors++;
        $display("FAIL R2 model reg_rdata actual=%h expected=%h t=%0t",
                 reg_rdata, m_rdata, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic sh_write(input logic [31:0] d);
    sh_wr = 1'b1; sh_addr = '0; sh_wdata = d;
    @(negedge clk);
    sh_wr = 1'b0;
  endtask

  task automatic sh_read(input logic [3:0] a, output logic [31:0] d);
    sh_addr = a;
    @(negedge clk);
    d = sh_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      rd(4'(a), v); check("R1 control byte after reset", v, 32'h0);
    end
    check("R1 irq_out after reset", {29'b0, irq_out}, 32'h0);

    // R2 layout and unmapped address
    wr(4'd1, 32'h0000_0030); idle(2);
    rd(4'd1, v); check("R2 readback en+sel", v, 32'h30);
    wr(4'd1, 32'hFFFF_FFFF); idle(2);
    rd(4'd1, v); check("R2 reserved bits read 0", v, 32'hF0);
    rd(4'd5, v); check("R2 unmapped address", v, 32'h0);

    // R4 strobe selection on line 1 (high level)
    slow_period = 0;
    wr(4'd1, 32'h20);
    pin_in[1] = 1'b1; idle(30);
    check("R4 no sample without slow strobe", {31'b0, irq_out[1]}, 32'h0);
    wr(4'd1, 32'h30); idle(8);
    check("R4 fast strobe samples", {31'b0, irq_out[1]}, 32'h1);
    // R5 write-1 ignored for level
    wr(4'd1, 32'h31); idle(4);
    rd(4'd1, v); check("R5 level pending unaffected by clear", v, 32'h31);
    check("R5 level request stays", {31'b0, irq_out[1]}, 32'h1);
    pin_in[1] = 1'b0; idle(8);
    check("R5 level follows pin low", {31'b0, irq_out[1]}, 32'h0);
    slow_period = 16;
    wr(4'd1, 32'h20); pin_in[1] = 1'b1; idle(40);
    check("R4 slow strobe samples", {31'b0, irq_out[1]}, 32'h1);
    pin_in[1] = 1'b0; idle(40);
    check("R4 slow strobe samples low", {31'b0, irq_out[1]}, 32'h0);

    // R10 low level on line 2
    wr(4'd2, 32'h70); idle(8);
    check("R10 low pin gives high request", {31'b0, irq_out[2]}, 32'h1);
    pin_in[2] = 1'b1; idle(8);
    check("R10 high pin drops request", {31'b0, irq_out[2]}, 32'h0);

    // R6 rising edge on line 0
    wr(4'd0, 32'hB0); idle(8);
    check("R6 no edge yet", {31'b0, irq_out[0]}, 32'h0);
    pin_in[0] = 1'b1; idle(8);
    check("R6 rising edge latched", {31'b0, irq_out[0]}, 32'h1);
    pin_in[0] = 1'b0; idle(8);
    check("R6 edge pending holds", {31'b0, irq_out[0]}, 32'h1);
    wr(4'd0, 32'hB1); idle(4);
    check("R6 write-1 clears", {31'b0, irq_out[0]}, 32'h0);
    // R6 falling edge on line 2 (pin2 is high)
    wr(4'd2, 32'hF0); idle(8);
    check("R6 fall type idle", {31'b0, irq_out[2]}, 32'h0);
    pin_in[2] = 1'b0; idle(8);
    check("R6 falling edge latched", {31'b0, irq_out[2]}, 32'h1);
    wr(4'd2, 32'h00); idle(4);

    // R8 mask keeps pending
    pin_in[0] = 1'b1; idle(8);
    wr(4'd0, 32'h90); idle(4);
    check("R8 disabled line is low", {31'b0, irq_out[0]}, 32'h0);
    rd(4'd0, v); check("R8 pending kept while masked", v, 32'h91);
    wr(4'd0, 32'hB0); idle(4);
    check("R8 unmask raises request", {31'b0, irq_out[0]}, 32'h1);
    wr(4'd0, 32'hB1); idle(4);

    // R7 clear and edge in the same sample cycle
    fast_period = 1;
    pin_in[0] = 1'b0; idle(8);
    wr(4'd0, 32'hB1); idle(4);
    check("R7 precondition cleared", {31'b0, irq_out[0]}, 32'h0);
    pin_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(4'd0, 32'hB1); idle(4);
    rd(4'd0, v); check("R7 edge wins over clear", v, 32'hB1);
    check("R7 request stays high", {31'b0, irq_out[0]}, 32'h1);
    fast_period = 2;

    // R9 type change discards stored sample
    wr(4'd0, 32'hB1); idle(8);
    slow_period = 0;
    wr(4'd0, 32'hA1); idle(4);
    pin_in[0] = 1'b0; idle(5);
    wr(4'd0, 32'hE0);
    wr(4'd0, 32'hF0); idle(10);
    check("R9 no false edge after type change", {31'b0, irq_out[0]}, 32'h0);
    pin_in[0] = 1'b1; idle(8);
    pin_in[0] = 1'b0; idle(8);
    check("R9 genuine fall still seen", {31'b0, irq_out[0]}, 32'h1);
    wr(4'd0, 32'h00);
    slow_period = 16;

    // R3 shared layout
    pin_in = '0; idle(10);
    sh_write(32'h0090_D010); idle(10);
    sh_read(4'd0, v); check("R3 shared word readback", v, 32'h0090_D010);
    sh_write(32'h00B0_D010); idle(4);
    pin_in[0] = 1'b1; idle(10);
    check("R3 line 0 request only", {29'b0, sh_irq}, 32'h1);
    sh_read(4'd0, v); check("R3 line 0 pending in bits 23:16", v, 32'h00B1_D010);
    sh_read(4'd1, v); check("R3 other address reads 0", v, 32'h0);

    idle(4);
    finish_run();
  end

endmodule